// File: doc/BRIEF.md
# SDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from power-up to a usable state. It drives chip select, the three command strobes, the address bus and the bank bus. After reset it holds the bus idle for a boot delay. It then precharges every bank at once and runs a configurable number of auto-refresh cycles, two by default. Next it writes the mode register with a word built from separate burst-length, burst-type, CAS-latency and write-burst inputs. After the mode-register settling time it raises a ready level. Every wait is a parameter counted in clock cycles, and one shared down-counter times all of them.

Mode inputs that the memory would not accept are replaced by safe defaults before they reach the bus. A sticky error flag reports that this happened. Once ready is up, a start pulse runs the whole sequence again from the boot delay.

Top module: `sdinit_seq`

## Requirements
- R1: Commands are driven as {ras_n_o, cas_n_o, we_n_o}: idle (NOP) 111, precharge 010, auto refresh 001, mode-register load 000. cs_n_o is 0 and ba_o is 0 at all times, including during reset. In idle cycles addr_o is 0.
- R2: While rst_ni is low, and for exactly TBOOT cycles counted from the cycle in which reset is released, the outputs carry idle with ready_o low.
- R3: The first command after the boot delay is a single-cycle precharge with addr_o[11:0] all ones, so bit 10 selects every bank. The bits of addr_o above bit 11 are 0.
- R4: The precharge is followed by exactly TRP idle cycles. Every non-idle command is followed by at least one idle cycle.
- R5: Exactly NUM_REFRESH single-cycle auto-refresh commands follow, with addr_o equal to 0. Each one is followed by exactly TRFC idle cycles.
- R6: A single-cycle mode-register load comes next. On addr_o it carries the burst-length code in bits 2:0 (codes 0..3 mean lengths 1, 2, 4, 8), the burst type in bit 3 (1 = interleaved), the CAS latency in bits 6:4, and write-single mode in bit 9.
- R7: In the mode word, the operating-mode bits 8:7 and the reserved bits 11:10 are always 0.
- R8: A burst-length code above 3 is replaced by 3, and a CAS latency other than 2 or 3 is replaced by 3. When either replacement is made, mode_err_o goes high in the cycle after the load and stays high until the sequence restarts or reset is applied.
- R9: ready_o rises after exactly TMRD idle cycles following the load. It then stays high while the bus stays idle, until a restart or reset.
- R10: start_i high while ready_o is high drops ready_o and clears mode_err_o in the next cycle, then repeats the full sequence from R2's boot delay.
- R11: start_i is ignored while the sequence is in progress: the command stream and its timing do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart request, honoured only while ready |
| burst_len_code_i | input | 3 | Burst-length code, 0..3 legal |
| burst_interleave_i | input | 1 | Burst type, 1 = interleaved |
| cas_lat_i | input | 3 | CAS latency, 2 or 3 legal |
| write_single_i | input | 1 | Write-burst mode, 1 = single-location writes |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank address |
| ready_o | output | 1 | Initialization complete |
| mode_err_o | output | 1 | Mode input was clamped |

## Verification
Almost every internal fault shows up on the command pins within one wait period. A stuck or misloaded down-counter shifts the next precharge, refresh or load by whole cycles, and a wrong refresh count adds or drops a 001 pulse before the load. The bench predicts the exact bus value for every cycle, so any such shift fails on the first cycle that differs. Faults in the mode-word assembly or the clamping only show during the single load cycle, or one cycle later on mode_err_o. For that reason the bench runs legal words, an illegal burst code and illegal CAS latencies, and uses a restart to prove that the error flag and the refresh count are cleared.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;
  localparam int unsigned MODE_W = 12;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRFC,
    ST_LMR,
    ST_TMRD,
    ST_READY
  } seq_state_e;
endpackage

// File: rtl/sdinit_wait_timer.sv
module sdinit_wait_timer #(
  parameter int unsigned       CNT_W   = 8,
  parameter logic [CNT_W-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= RST_VAL;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R4: an expired count holds at zero until reloaded, never wraps
  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && done_o) |=> done_o);

  // R2: a reload of a non-zero count is not immediately done
  a_r2_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> !done_o);
endmodule

// File: rtl/sdinit_mode_word.sv
module sdinit_mode_word
  import sdinit_pkg::*;
(
  input  logic [2:0]        burst_len_code_i,
  input  logic              burst_interleave_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              write_single_i,
  output logic [MODE_W-1:0] word_o,
  output logic              clamped_o
);
  logic       bl_ok, cas_ok;
  logic [2:0] bl_f, cas_f;

  always_comb begin
    bl_ok  = (burst_len_code_i <= 3'd3);
    cas_ok = (cas_lat_i == 3'd2) || (cas_lat_i == 3'd3);
    bl_f   = bl_ok  ? burst_len_code_i : 3'd3;
    cas_f  = cas_ok ? cas_lat_i        : 3'd3;
    // [11:10] reserved, [9] write mode, [8:7] op mode, [6:4] CL, [3] type, [2:0] BL
    word_o    = {2'b00, write_single_i, 2'b00, cas_f, burst_interleave_i, bl_f};
    clamped_o = !(bl_ok && cas_ok);
  end
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned TBOOT       = 25000,
  parameter int unsigned TRP         = 3,
  parameter int unsigned TRFC        = 9,
  parameter int unsigned TMRD        = 2,
  parameter int unsigned NUM_REFRESH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        burst_len_code_i,
  input  logic              burst_interleave_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              write_single_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o,
  output logic              mode_err_o
);
  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned T_MAX = max2(max2(TBOOT, TRP), max2(TRFC, TMRD));
  localparam int unsigned CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;
  localparam int unsigned REF_W = $clog2(NUM_REFRESH + 1);
  localparam logic [CNT_W-1:0] BOOT_LD = CNT_W'(TBOOT - 1);
  localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP - 1);
  localparam logic [CNT_W-1:0] TRFC_LD = CNT_W'(TRFC - 1);
  localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REFRESH);

  seq_state_e        state_q, state_d;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              wait_done;
  logic [REF_W-1:0]  ref_cnt_q;
  logic              mode_err_q;
  logic [MODE_W-1:0] mode_word;
  logic              mode_clamped;
  sd_cmd_e           cmd;
  logic              restart;

  sdinit_wait_timer #(.CNT_W(CNT_W), .RST_VAL(BOOT_LD)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .done_o     (wait_done)
  );

  sdinit_mode_word u_mode (
    .burst_len_code_i   (burst_len_code_i),
    .burst_interleave_i (burst_interleave_i),
    .cas_lat_i          (cas_lat_i),
    .write_single_i     (write_single_i),
    .word_o             (mode_word),
    .clamped_o          (mode_clamped)
  );

  assign restart = (state_q == ST_READY) && start_i;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = BOOT_LD;
    unique case (state_q)
      ST_BOOT:  if (wait_done) state_d = ST_PRE;
      ST_PRE:   begin ld = 1'b1; ld_val = TRP_LD;  state_d = ST_TRP;  end
      ST_TRP:   if (wait_done) state_d = ST_REF;
      ST_REF:   begin ld = 1'b1; ld_val = TRFC_LD; state_d = ST_TRFC; end
      ST_TRFC:  if (wait_done) state_d = (ref_cnt_q == REF_LAST) ? ST_LMR : ST_REF;
      ST_LMR:   begin ld = 1'b1; ld_val = TMRD_LD; state_d = ST_TMRD; end
      ST_TMRD:  if (wait_done) state_d = ST_READY;
      ST_READY: if (start_i) begin ld = 1'b1; ld_val = BOOT_LD; state_d = ST_BOOT; end
      default:  state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_BOOT;
      ref_cnt_q  <= '0;
      mode_err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (restart)                ref_cnt_q <= '0;
      else if (state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
      if (restart)                mode_err_q <= 1'b0;
      else if (state_q == ST_LMR) mode_err_q <= mode_clamped;
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    unique case (state_q)
      ST_PRE:  begin cmd = CMD_PRE; addr_o = ADDR_W'(12'hFFF); end
      ST_REF:  cmd = CMD_REF;
      ST_LMR:  begin cmd = CMD_LMR; addr_o = ADDR_W'(mode_word); end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cs_n_o     = 1'b0;
  assign ba_o       = '0;
  assign ready_o    = (state_q == ST_READY);
  assign mode_err_o = mode_err_q;

  // R3: precharge selects all banks
  a_r3_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} == 3'b010) |-> (addr_o[11:0] == 12'hFFF));

  // R4: every command is followed by an idle cycle
  a_r4_gap_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} != 3'b111) |=> ({ras_n_o, cas_n_o, we_n_o} == 3'b111));

  // R7: reserved and op-mode bits zero on load
  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} == 3'b000) |-> (addr_o[11:10] == 2'b00 && addr_o[8:7] == 2'b00));

  // R8: loaded fields are always legal
  a_r8_fields_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} == 3'b000) |->
      (addr_o[2] == 1'b0 && (addr_o[6:4] == 3'd2 || addr_o[6:4] == 3'd3)));

  // R8: error flag only rises right after a load
  a_r8_err_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_err_o) |-> ($past({ras_n_o, cas_n_o, we_n_o}) == 3'b000));

  // R9: ready holds and bus stays idle
  a_r9_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o);
  a_r9_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ({ras_n_o, cas_n_o, we_n_o} == 3'b111));

  // R10: restart drops ready and clears error
  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> (!ready_o && !mode_err_o));

  // R1: chip select and bank fixed
  a_r1_cs_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && ba_o == '0));
endmodule

// File: tb/sdinit_seq_test.sv
`timescale 1ns/1ps
module sdinit_seq_test;
  localparam int TBOOT = 12, TRP = 3, TRFC = 5, TMRD = 2, NREF = 2;

  typedef struct {
    logic [2:0]  cmd;
    logic [12:0] addr;
    logic        rdy;
    logic        err;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [2:0] bl_i = 3'd3, cas_i = 3'd3;
  logic intl_i = 1'b0, ws_i = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, rdy, err;
  logic [12:0] addr;
  logic [1:0] ba;

  int checks = 0, fails = 0;
  bit finished = 0;
  item_t q[$];

  always #4 clk = ~clk;

  sdinit_seq #(.ADDR_W(13), .BA_W(2), .TBOOT(TBOOT), .TRP(TRP), .TRFC(TRFC),
               .TMRD(TMRD), .NUM_REFRESH(NREF)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .burst_len_code_i(bl_i), .burst_interleave_i(intl_i),
    .cas_lat_i(cas_i), .write_single_i(ws_i),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .addr_o(addr), .ba_o(ba), .ready_o(rdy), .mode_err_o(err));

  // driver: push expectation for this cycle, then advance
  task automatic step(input logic [2:0] c, input logic [12:0] a,
                      input logic r, input logic e, input string tag);
    item_t it;
    it.cmd = c; it.addr = a; it.rdy = r; it.err = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic run_init(input logic [2:0] bl, input logic il, input logic [2:0] cl,
                          input logic ws, input bit poke_start, input int n_ready,
                          input bit restart_at_end);
    logic [2:0] bl_c, cl_c;
    logic [12:0] word;
    logic e;
    bl_i = bl; intl_i = il; cas_i = cl; ws_i = ws;
    bl_c = (bl > 3'd3) ? 3'd3 : bl;
    cl_c = (cl == 3'd2 || cl == 3'd3) ? cl : 3'd3;
    word = {3'b000, ws, 2'b00, cl_c, il, bl_c};
    e = (bl > 3'd3) || !(cl == 3'd2 || cl == 3'd3);
    for (int i = 0; i < TBOOT; i++) begin
      start_i = poke_start && (i >= 3 && i <= 5);  // R11
      step(3'b111, 13'h0, 1'b0, 1'b0, (i >= 3 && i <= 5) ? "R11" : "R2");
    end
    start_i = 1'b0;
    step(3'b010, 13'h0FFF, 1'b0, 1'b0, "R3");
    for (int i = 0; i < TRP; i++) step(3'b111, 13'h0, 1'b0, 1'b0, "R4");
    for (int r = 0; r < NREF; r++) begin
      step(3'b001, 13'h0, 1'b0, 1'b0, "R5");
      for (int i = 0; i < TRFC; i++) begin
        start_i = poke_start && (i == 1);            // R11
        step(3'b111, 13'h0, 1'b0, 1'b0, "R5");
      end
      start_i = 1'b0;
    end
    step(3'b000, word, 1'b0, 1'b0, e ? "R8" : "R6");
    for (int i = 0; i < TMRD; i++) step(3'b111, 13'h0, 1'b0, e, "R9");
    for (int i = 0; i < n_ready; i++) step(3'b111, 13'h0, 1'b1, e, "R9");
    if (restart_at_end) begin
      start_i = 1'b1;
      step(3'b111, 13'h0, 1'b1, e, "R10");
      start_i = 1'b0;
    end
  endtask

  // monitor: compare away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({ras_n, cas_n, we_n} !== it.cmd || addr !== it.addr ||
            rdy !== it.rdy || err !== it.err) begin
          fails++;
          $display("FAIL %s: actual cmd=%b addr=%h rdy=%b err=%b expected cmd=%b addr=%h rdy=%b err=%b",
                   it.tag, {ras_n, cas_n, we_n}, addr, rdy, err,
                   it.cmd, it.addr, it.rdy, it.err);
        end
        checks++;
        if (cs_n !== 1'b0 || ba !== 2'b00) begin
          fails++;
          $display("FAIL R1: actual cs_n=%b ba=%b expected cs_n=0 ba=0", cs_n, ba);
        end
      end
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(3'b111, 13'h0, 1'b0, 1'b0, "R2");
    rst_ni = 1'b1;
    run_init(3'd3, 1'b0, 3'd3, 1'b0, 1'b1, 4, 1'b1);   // R6 default word, R11
    run_init(3'd1, 1'b1, 3'd2, 1'b1, 1'b0, 3, 1'b1);   // R6 other fields
    run_init(3'd5, 1'b0, 3'd1, 1'b0, 1'b0, 3, 1'b1);   // R8 both clamped, R10 clears
    run_init(3'd0, 1'b1, 3'd7, 1'b0, 1'b1, 5, 1'b0);   // R8 CAS only
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9: watchdog actual=hung expected=sequence complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule